// File: doc/BRIEF.md
# Mersenne-Prime Keyed Inner-Product Hash

The block reduces a pair of message words to a single residue modulo the Mersenne prime p = 2^EXP - 1 (EXP is 61 by default). Each word is below 2^(EXP-1) and is multiplied by its own secret key. The two products are reduced by folding, summed, folded again and range-corrected once. When the caller sets the tag flag for a transaction, a pad value below p is added modulo p to the hash. This turns the hash into a final authentication tag. The pad normally comes from a cipher applied to a nonce, and it is produced outside this block.

Transactions use a valid/ready stream on both sides. An input is accepted on a rising edge where `in_valid` and `in_ready` are both high. The block then holds only that one transaction, and `in_ready` stays low until the result has been taken. The result is offered with `out_valid`. If the consumer holds `out_ready` low, the block keeps `out_valid` and `out_data` unchanged until the consumer raises `out_ready`. The words, keys, pad and tag flag are all sampled on the accepting edge only.

Top module: `mersenne_inner_hash`

## Requirements
- R1: With the tag flag low, the result equals (a1*k1 + a2*k2) mod p, where p = 2^EXP - 1.
- R2: The result is exact for every word in 0..2^(EXP-1)-1 and every key in 0..p-1, including the largest words paired with the largest keys.
- R3: The internal hash, formed after the folded sum has had one conditional subtraction of p, lies in 0..p-1. A sum that is a non-zero multiple of p yields 0.
- R4: `out_data` is always below p while `out_valid` is high.
- R5: With the tag flag high, the result equals (hash + pad) mod p for any pad in 0..p-1. Boundary cases such as hash + pad = p wrap to 0.
- R6: `in_ready` drops on the edge after an acceptance and rises again only after the result has been taken. Input data held or changed while busy does not affect the pending result.
- R7: `out_valid` rises at the third rising edge after the accepting edge. While `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R8: After reset, `in_ready` is 1 and `out_valid` is 0.
- R9: With the tag flag low, the pad input has no effect on `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input transaction offered |
| in_ready | output | 1 | Block is idle and can accept a transaction |
| in_a1 | input | EXP-1 | First message word |
| in_a2 | input | EXP-1 | Second message word |
| in_k1 | input | EXP | Key for the first word, below p |
| in_k2 | input | EXP | Key for the second word, below p |
| in_pad | input | EXP | Pad added in tag mode, below p |
| in_tag_en | input | 1 | 1: add the pad; 0: plain hash |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | EXP | Hash or tag, in 0..p-1 |

## Verification
Several properties are checked on every cycle:
- each folded lane term stays congruent to its product modulo p;
- the corrected hash and the output stay below p;
- a result held under back-pressure does not change;
- acceptance closes `in_ready` and produces `out_valid` exactly three edges later.

Exact arithmetic cannot be shown by these properties alone. This includes wrap-to-zero at multiples of p and pad additions that cross p. For a small prime these are shown only by the bench, which sweeps every word pair against varied keys and pads. The bench scenarios also show three more behaviours:
- the pad is ignored outside tag mode;
- inputs held or changed while busy do not affect the result;
- a result stays intact across a stall.

// File: rtl/mih_pkg.sv
package mih_pkg;
  localparam int NUM_TERMS = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PROD = 2'd1,
    ST_HASH = 2'd2,
    ST_DONE = 2'd3
  } mih_state_t;
endpackage

// File: rtl/mersenne_fold.sv
module mersenne_fold #(
  parameter int EXP   = 61,
  parameter int IN_W  = 121,
  parameter int OUT_W = 62
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  // 2^EXP == 1 (mod 2^EXP - 1): add the high part onto the low part
  assign dout = OUT_W'(din[IN_W-1:EXP]) + OUT_W'(din[EXP-1:0]);
endmodule

// File: rtl/mod_correct.sv
module mod_correct #(
  parameter int EXP  = 61,
  parameter int IN_W = 62
) (
  input  logic [IN_W-1:0] din,
  output logic [EXP-1:0]  dout
);
  localparam logic [EXP-1:0] PRIME = {EXP{1'b1}};

  logic [EXP-1:0] low_minus_p;

  // valid for din < 2*PRIME: the difference fits in EXP bits
  assign low_minus_p = din[EXP-1:0] - PRIME;
  assign dout = (din >= IN_W'(PRIME)) ? low_minus_p : din[EXP-1:0];
endmodule

// File: rtl/keyed_term.sv
module keyed_term #(
  parameter int EXP = 61
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [EXP-2:0] word,
  input  logic [EXP-1:0] key,
  output logic [EXP:0]   term
);
  localparam int PROD_W = 2 * EXP - 1;
  localparam int TERM_W = EXP + 1;
  localparam logic [EXP-1:0] PRIME = {EXP{1'b1}};

  logic [PROD_W-1:0] prod;
  logic [TERM_W-1:0] folded;

  assign prod = PROD_W'(word) * PROD_W'(key);

  mersenne_fold #(.EXP(EXP), .IN_W(PROD_W), .OUT_W(TERM_W)) u_fold (
    .din  (prod),
    .dout (folded)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    term <= '0;
    else if (load) term <= folded;
  end

  // R1: the stored term is congruent to the product of the loaded operands
  p_term_congruent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((PROD_W'(term) % PROD_W'(PRIME)) ==
              ((PROD_W'($past(word)) * PROD_W'($past(key))) % PROD_W'(PRIME))));
endmodule

// File: rtl/mersenne_inner_hash.sv
module mersenne_inner_hash #(
  parameter int EXP = 61
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [EXP-2:0] in_a1,
  input  logic [EXP-2:0] in_a2,
  input  logic [EXP-1:0] in_k1,
  input  logic [EXP-1:0] in_k2,
  input  logic [EXP-1:0] in_pad,
  input  logic           in_tag_en,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [EXP-1:0] out_data
);
  import mih_pkg::*;

  localparam int WORD_W = EXP - 1;
  localparam int TERM_W = EXP + 1;
  localparam int SUM_W  = TERM_W + $clog2(NUM_TERMS);
  localparam logic [EXP-1:0] PRIME = {EXP{1'b1}};

  mih_state_t state_q;
  logic       accept;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_DONE);
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else begin
      case (state_q)
        ST_IDLE: if (accept) state_q <= ST_PROD;
        ST_PROD: state_q <= ST_HASH;
        ST_HASH: state_q <= ST_DONE;
        ST_DONE: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // ---- product lanes ----
  logic [WORD_W-1:0] lane_word [NUM_TERMS];
  logic [EXP-1:0]    lane_key  [NUM_TERMS];
  logic [TERM_W-1:0] lane_term [NUM_TERMS];

  assign lane_word[0] = in_a1;
  assign lane_word[1] = in_a2;
  assign lane_key[0]  = in_k1;
  assign lane_key[1]  = in_k2;

  for (genvar g = 0; g < NUM_TERMS; g++) begin : g_lane
    keyed_term #(.EXP(EXP)) u_term (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .word  (lane_word[g]),
      .key   (lane_key[g]),
      .term  (lane_term[g])
    );
  end

  // pad and mode travel with the transaction
  logic [EXP-1:0] pad_q;
  logic           tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q <= '0;
      tag_q <= 1'b0;
    end else if (accept) begin
      pad_q <= in_pad;
      tag_q <= in_tag_en;
    end
  end

  // ---- sum, fold, single correction ----
  logic [SUM_W-1:0] term_sum;
  logic [EXP:0]     sum_folded;
  logic [EXP-1:0]   hash_c;
  logic [EXP-1:0]   hash_q;

  always_comb begin
    term_sum = '0;
    for (int i = 0; i < NUM_TERMS; i++) term_sum = term_sum + SUM_W'(lane_term[i]);
  end

  mersenne_fold #(.EXP(EXP), .IN_W(SUM_W), .OUT_W(EXP + 1)) u_sum_fold (
    .din  (term_sum),
    .dout (sum_folded)
  );

  mod_correct #(.EXP(EXP), .IN_W(EXP + 1)) u_hash_corr (
    .din  (sum_folded),
    .dout (hash_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   hash_q <= '0;
    else if (state_q == ST_PROD)  hash_q <= hash_c;
  end

  // ---- optional pad addition ----
  logic [EXP:0]   tag_sum;
  logic [EXP-1:0] tag_c;
  logic [EXP-1:0] out_q;

  assign tag_sum = tag_q ? ((EXP + 1)'(hash_q) + (EXP + 1)'(pad_q)) : (EXP + 1)'(hash_q);

  mod_correct #(.EXP(EXP), .IN_W(EXP + 1)) u_tag_corr (
    .din  (tag_sum),
    .dout (tag_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   out_q <= '0;
    else if (state_q == ST_HASH)  out_q <= tag_c;
  end

  assign out_data = out_q;

  // ---- assertions ----
  p_hash_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HASH) |-> (hash_q < PRIME));

  p_out_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data < PRIME));

  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !out_valid ##1 !out_valid ##1 out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/mersenne_inner_hash_bench.sv
module mersenne_inner_hash_bench;
  localparam int E = 7;
  localparam int P = (1 << E) - 1;
  localparam int AMAX = 1 << (E - 1);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [E-2:0] in_a1 = '0;
  logic [E-2:0] in_a2 = '0;
  logic [E-1:0] in_k1 = '0;
  logic [E-1:0] in_k2 = '0;
  logic [E-1:0] in_pad = '0;
  logic         in_tag_en = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [E-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mersenne_inner_hash #(.EXP(E)) u_mersenne_inner_hash (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a1(in_a1), .in_a2(in_a2), .in_k1(in_k1), .in_k2(in_k2),
    .in_pad(in_pad), .in_tag_en(in_tag_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_txn(input int a1, input int a2, input int k1, input int k2,
                         input int pad, input bit tag, input int hold,
                         input bit keep, input string req);
    int h;
    int exp;
    logic [E-1:0] seen;
    h   = (a1 * k1 + a2 * k2) % P;
    exp = tag ? (h + pad) % P : h;
    @(negedge clk);
    in_a1 = (E-1)'(a1); in_a2 = (E-1)'(a2);
    in_k1 = E'(k1); in_k2 = E'(k2);
    in_pad = E'(pad); in_tag_en = tag;
    in_valid = 1'b1;
    out_ready = (hold == 0);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    if (keep) begin
      // R6: scramble inputs while busy
      in_a1 = ~in_a1; in_a2 = ~in_a2; in_k1 = E'(P - 1 - k1);
      in_pad = E'((pad + 1) % P); in_tag_en = ~tag;
    end else in_valid = 1'b0;
    check(in_ready == 1'b0, "R6 busy", int'(in_ready), 0);
    check(out_valid == 1'b0, "R7 early", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 early", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R7 latency", int'(out_valid), 1);
    check(int'(out_data) == exp, req, int'(out_data), exp);
    check(int'(out_data) < P, "R4 range", int'(out_data), P - 1);
    seen = out_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(out_valid == 1'b1 && out_data == seen, "R7 hold", int'(out_data), int'(seen));
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R6 taken", int'(out_valid), 0);
    check(in_ready == 1'b1, "R6 reopen", int'(in_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check(in_ready == 1'b1, "R8 in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R8 out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R8 after release", int'(out_valid), 0);

    // R1: plain hash sweep over all word pairs
    for (int a1 = 0; a1 < AMAX; a1++)
      for (int a2 = 0; a2 < AMAX; a2++)
        run_txn(a1, a2, (a1 * 29 + a2 * 3 + 5) % P, (a2 * 17 + a1 * 7 + 11) % P,
                0, 1'b0, 0, 1'b0, "R1 hash");

    // R5: tag mode sweep with varied pads
    for (int a1 = 0; a1 < AMAX; a1++)
      for (int a2 = 0; a2 < AMAX; a2++)
        run_txn(a1, a2, (a1 * 13 + a2 + 1) % P, (a2 * 41 + a1 * 5) % P,
                (a1 * 9 + a2 * 23 + 3) % P, 1'b1, 0, 1'b0, "R5 tag");

    // R9: pad ignored when tag flag is low
    for (int a1 = 0; a1 < AMAX; a1 += 3)
      for (int a2 = 0; a2 < AMAX; a2++)
        run_txn(a1, a2, (a1 * 31 + a2 * 11) % P, (a2 * 19 + 7) % P,
                (a1 * 53 + a2 * 61 + 17) % P, 1'b0, 0, 1'b0, "R9 pad ignored");

    // R2: extreme words and keys
    run_txn(AMAX - 1, AMAX - 1, P - 1, P - 1, 0, 1'b0, 0, 1'b0, "R2 max");
    run_txn(AMAX - 1, 0, P - 1, 0, 0, 1'b0, 0, 1'b0, "R2 max lane1");
    run_txn(0, AMAX - 1, 0, P - 1, 0, 1'b0, 0, 1'b0, "R2 max lane2");
    run_txn(AMAX - 1, AMAX - 1, 0, 0, 0, 1'b0, 0, 1'b0, "R2 zero keys");
    // R3: sums that are multiples of p give 0
    run_txn(1, AMAX - 1, AMAX, 1, 0, 1'b0, 0, 1'b0, "R3 sum p");
    run_txn(2, AMAX - 1, AMAX, 2, 0, 1'b0, 0, 1'b0, "R3 sum 2p");
    // R5: pad boundaries (hash 1 + pad p-1 wraps to 0; hash p-1 + pad p-1)
    run_txn(1, 0, 1, 0, P - 1, 1'b1, 0, 1'b0, "R5 wrap zero");
    run_txn(1, 0, P - 1, 0, P - 1, 1'b1, 0, 1'b0, "R5 max pad");
    run_txn(0, 0, 5, 9, P - 1, 1'b1, 0, 1'b0, "R5 zero hash");
    // R7: back-pressure
    run_txn(AMAX - 1, 17, 100, 45, 0, 1'b0, 4, 1'b0, "R7 stalled result");
    run_txn(33, 9, 77, 120, 60, 1'b1, 2, 1'b0, "R7 stalled tag");
    // R6: inputs held and scrambled while busy
    run_txn(21, 40, 90, 3, 50, 1'b1, 0, 1'b1, "R6 busy inputs");
    run_txn(63, 62, 125, 124, 10, 1'b0, 3, 1'b1, "R6 busy stalled");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule